// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that holds a byte-wide storage array behind a 15-bit address pointer. A system clock oversamples the bus clock and data lines. From the sampled lines the block detects start, stop and repeated-start conditions and runs a byte-level protocol engine. Writes land in the array on the bus clock edge that completes the byte, so there is no busy period and no need to poll for completion. The next transaction can begin at once.

After a write-direction address the master sends two pointer bytes, high byte first, and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read-direction address returns bytes starting at the pointer, which is kept from the last access. A write that carries only the two pointer bytes, followed by a repeated start and a read-direction address, therefore gives a random read. A write-protect input refuses data bytes and holds the pointer still. The data output is an open-drain enable: when it is high the pad pulls SDA low.

Top module: `i2cmem_target`

## Requirements
- R1: The address byte is accepted (ACK, data line pulled low during the ninth clock) only if bits 7..4 equal 1010b and bits 3..1 equal `strapAddr`. Bit 0 selects the direction, 1 for read. On a mismatch the block never pulls the data line low until the next start, so bytes clocked out read as 0xFF.
- R2: After a write-direction address, the next two bytes are ACKed and loaded into the pointer, high byte first. The top bit of the high byte is ignored, which gives a 15-bit pointer.
- R3: Bytes move most significant bit first. Input bits are taken on rising SCL, and `sdaOe` changes only while SCL is low.
- R4: The pointer advances by one after each data byte. It wraps from 7FFFh to 0000h, and a burst has no length limit. The array has 2^MEM_AW bytes, indexed by the low MEM_AW pointer bits (256 bytes by default).
- R5: A data byte is stored when its eighth bit is received, before the ACK. A stop or start before the eighth bit leaves the array unchanged.
- R6: While `wrProtect` is high, data bytes are NACKed, the array is not written and the pointer does not move. The address byte and the pointer bytes are still ACKed.
- R7: On a matched read, the block sends the byte at the pointer right after the address ACK. It keeps sending successive bytes while the master ACKs, and releases the data line after a NACK.
- R8: A repeated start after the pointer bytes abandons the write, and a following read starts at the newly loaded pointer.
- R9: A start at any point aborts the current operation and expects an address byte. A stop ends any operation. After either, the data line is released.
- R10: System reset clears the pointer to 0 and does not clear the array. The pointer persists across transactions, so a current-address read continues after the last byte accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level as seen on the wire |
| strapAddr | input | 3 | Board-strapped target select bits |
| wrProtect | input | 1 | High refuses data writes |
| sdaOe | output | 1 | High pulls the data line low (open drain) |

## Verification
Storing a byte and advancing the pointer fall on the same cycle: the rising SCL edge of the eighth data bit. Write protect gates both. The bench provokes this with bursts that cross the 7FFFh wrap and with a protected write. It judges the result only through later random and current-address reads against a byte model kept in the bench. Aborts by stop and by repeated start a few bits into a byte are judged the same way.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  // Strobes from the protocol control to the datapath
  typedef struct packed {
    logic shiftIn;    // capture one received bit
    logic holdPtrHi;  // park the high pointer byte
    logic loadPtr;    // load pointer from parked high + received low
    logic writeMem;   // store received byte at pointer
    logic incPtr;     // advance pointer
    logic loadTx;     // fetch byte at pointer into transmit shifter
    logic shiftTx;    // move to next transmit bit
  } dpCtrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RXBIT, S_RXWAIT, S_ACKOUT, S_TXBIT, S_ACKIN, S_ACKWAIT
  } state_t;

  typedef enum logic [2:0] {
    K_ADDR, K_PTRHI, K_PTRLO, K_DATA, K_READ
  } byteKind_t;

endpackage

// File: rtl/i2cmem_linesync.sv
module i2cmem_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[TOP];
      sdaPrev <= sdaPipe[TOP];
    end
  end

  assign sclLvl   = sclPipe[TOP];
  assign sdaLvl   = sdaPipe[TOP];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2cmem_datapath.sv
module i2cmem_datapath
  import i2cmem_pkg::*;
#(
  parameter int PTR_W  = 15,
  parameter int MEM_AW = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctl,
  input  logic       sdaLvl,
  output logic [7:0] rxNext,
  output logic       txBit
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int HI_W  = PTR_W - 8;

  logic [7:0]       rxShift, txShift;
  logic [7:0]       mem [DEPTH];
  logic [HI_W-1:0]  ptrHiHold;
  logic [PTR_W-1:0] ptr;
  logic [MEM_AW-1:0] memIdx;

  assign rxNext = {rxShift[6:0], sdaLvl};
  assign txBit  = txShift[7];
  assign memIdx = ptr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '1;
      ptrHiHold <= '0;
      ptr       <= '0;
    end else begin
      if (ctl.shiftIn)   rxShift   <= rxNext;
      if (ctl.holdPtrHi) ptrHiHold <= rxNext[HI_W-1:0];
      if (ctl.loadPtr)     ptr <= {ptrHiHold, rxNext};
      else if (ctl.incPtr) ptr <= ptr + 1'b1;
      if (ctl.loadTx)       txShift <= mem[memIdx];
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  // Array is not reset: contents survive a system reset
  always_ff @(posedge clk) begin
    if (ctl.writeMem) mem[memIdx] <= rxNext;
  end

  // R6: pointer holds unless control asks for a load or an advance
  assert_ptr_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.incPtr && !ctl.loadPtr) |=> $stable(ptr));

  // R4: an advance steps by exactly one, modulo the pointer width
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incPtr && !ctl.loadPtr) |=> (ptr == $past(ptr) + 1'b1));

  // R5: one array access per cycle
  assert_single_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.writeMem, ctl.loadTx, ctl.loadPtr}));

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter logic [3:0] DEVICE_TYPE = 4'b1010,
  parameter int         STRAP_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclLvl,
  input  logic               sdaLvl,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               wrProtect,
  input  logic [7:0]         rxNext,
  input  logic               txBit,
  output dpCtrl_t            ctl,
  output logic               sdaOe
);
  localparam logic [2:0] LAST_BIT = 3'd7;

  state_t    state, stateN;
  byteKind_t kind, kindN;
  logic [2:0] bitCnt, cntN;
  logic       ackDrive, ackN;
  logic       addrHit;

  assign addrHit = (rxNext[7:4] == DEVICE_TYPE) && (rxNext[STRAP_W:1] == strapAddr);

  always_comb begin
    ctl    = '0;
    stateN = state;
    kindN  = kind;
    cntN   = bitCnt;
    ackN   = ackDrive;
    if (stopDet) begin
      stateN = S_IDLE;
    end else if (startDet) begin
      stateN = S_RXBIT;
      kindN  = K_ADDR;
      cntN   = '0;
    end else begin
      case (state)
        S_RXBIT: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          cntN = bitCnt + 3'd1;
          if (bitCnt == LAST_BIT) begin
            stateN = S_RXWAIT;
            ackN   = 1'b1;
            case (kind)
              K_ADDR: begin
                if (!addrHit) stateN = S_IDLE;
                else if (rxNext[0]) begin
                  kindN = K_READ;
                  ctl.loadTx = 1'b1;
                end else kindN = K_PTRHI;
              end
              K_PTRHI: begin
                ctl.holdPtrHi = 1'b1;
                kindN = K_PTRLO;
              end
              K_PTRLO: begin
                ctl.loadPtr = 1'b1;
                kindN = K_DATA;
              end
              default: begin
                if (wrProtect) ackN = 1'b0;
                else begin
                  ctl.writeMem = 1'b1;
                  ctl.incPtr   = 1'b1;
                end
              end
            endcase
          end
        end
        S_RXWAIT: if (sclFall) stateN = S_ACKOUT;
        S_ACKOUT: if (sclFall) begin
          cntN = '0;
          if (!ackDrive)          stateN = S_IDLE;
          else if (kind == K_READ) stateN = S_TXBIT;
          else                    stateN = S_RXBIT;
        end
        S_TXBIT: if (sclFall) begin
          if (bitCnt == LAST_BIT) begin
            stateN = S_ACKIN;
            ctl.incPtr = 1'b1;
            cntN = '0;
          end else begin
            ctl.shiftTx = 1'b1;
            cntN = bitCnt + 3'd1;
          end
        end
        S_ACKIN: if (sclRise) begin
          if (!sdaLvl) begin
            ctl.loadTx = 1'b1;
            stateN = S_ACKWAIT;
          end else stateN = S_IDLE;
        end
        S_ACKWAIT: if (sclFall) stateN = S_TXBIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else begin
      state    <= stateN;
      kind     <= kindN;
      bitCnt   <= cntN;
      ackDrive <= ackN;
    end
  end

  assign sdaOe = ((state == S_ACKOUT) && ackDrive) || ((state == S_TXBIT) && !txBit);

  // R3: the data line only moves while the bus clock is low
  assert_sda_moves_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    sclLvl |-> $stable(sdaOe));

  // R6: a protected write never reaches the array
  assert_protect_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeMem |-> !wrProtect);

  // R9: a start releases the line
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  // R9: a stop releases the line
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
  import i2cmem_pkg::*;
#(
  parameter int         PTR_W       = 15,
  parameter int         MEM_AW      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEVICE_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       wrProtect,
  output logic       sdaOe
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxNext;
  logic txBit;
  dpCtrl_t ctl;

  i2cmem_linesync #(.SYNC_STAGES(SYNC_STAGES)) i_linesync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cmem_ctrl #(.DEVICE_TYPE(DEVICE_TYPE), .STRAP_W(3)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .strapAddr(strapAddr), .wrProtect(wrProtect), .rxNext(rxNext), .txBit(txBit),
    .ctl(ctl), .sdaOe(sdaOe)
  );

  i2cmem_datapath #(.PTR_W(PTR_W), .MEM_AW(MEM_AW)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl),
    .rxNext(rxNext), .txBit(txBit)
  );

endmodule

// File: tb/test_i2cmem_target.sv
module test_i2cmem_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 200000;
  localparam logic [2:0] MY_STRAP = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic wp = 1'b0;
  logic sdaOe;
  logic sdaLine;
  int total = 0;
  int bad = 0;
  logic [7:0] model [256];

  assign sdaLine = mSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cmem_target i_i2cmem_target (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .strapAddr(MY_STRAP), .wrProtect(wp), .sdaOe(sdaOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    halfWait();
  endtask

  task automatic busStart();
    mSda = 1'b1; halfWait();
    mScl = 1'b1; halfWait();
    mSda = 1'b0; halfWait();
    mScl = 1'b0; halfWait();
  endtask

  task automatic busStop();
    mSda = 1'b0; halfWait();
    mScl = 1'b1; halfWait();
    mSda = 1'b1; halfWait();
  endtask

  task automatic bitOut(input logic v);
    mSda = v; halfWait();
    mScl = 1'b1; halfWait();
    mScl = 1'b0; halfWait();
  endtask

  task automatic bitIn(output logic v);
    mSda = 1'b1; halfWait();
    mScl = 1'b1; halfWait();
    v = sdaLine;
    mScl = 1'b0; halfWait();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    bitIn(a);
    acked = (a == 1'b0);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    logic v;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bitIn(v);
      b = {b[6:0], v};
    end
    bitOut(ackIt ? 1'b0 : 1'b1);
  endtask

  function automatic logic [7:0] addrB(input logic [2:0] sel, input logic rw);
    return {4'b1010, sel, rw};
  endfunction

  function automatic logic [7:0] dataFor(input int a, input int salt);
    return 8'((a * 37 + 11 + salt * 13) & 8'hFF);
  endfunction

  task automatic setPtr(input logic [14:0] p);
    bit ak;
    busStart();
    sendByte(addrB(MY_STRAP, 1'b0), ak);
    check(ak, "R1 write address ack", int'(ak), 1);
    sendByte({1'b0, p[14:8]}, ak);
    check(ak, "R2 pointer high ack", int'(ak), 1);
    sendByte(p[7:0], ak);
    check(ak, "R2 pointer low ack", int'(ak), 1);
  endtask

  // Reads n bytes from the current pointer after a (repeated) start
  task automatic readRun(input int startIdx, input int n, input string tag);
    bit ak;
    logic [7:0] got;
    busStart();
    sendByte(addrB(MY_STRAP, 1'b1), ak);
    check(ak, "R7 read address ack", int'(ak), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, got);
      check(got == model[(startIdx + k) & 8'hFF], tag, got, model[(startIdx + k) & 8'hFF]);
    end
    check(sdaOe == 1'b0, "R7 released after NACK", int'(sdaOe), 0);
    busStop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", WATCHDOG, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] got;
    int bases [3];
    bases[0] = 15'h0010;
    bases[1] = 15'h1234;
    bases[2] = 15'h7FFE;

    doReset();
    check(sdaOe == 1'b0, "R10 reset releases line", int'(sdaOe), 0);

    // Store a known byte at 0, then reset: R10 pointer cleared, array kept
    setPtr(15'h0000);
    sendByte(8'hA5, ak);
    check(ak, "R5 data ack", int'(ak), 1);
    model[0] = 8'hA5;
    busStop();
    doReset();
    readRun(0, 1, "R10 reset pointer and kept array");

    // R1: sweep of strap selects plus a wrong type nibble
    for (int sel = 0; sel < 8; sel++) begin
      busStart();
      sendByte(addrB(3'(sel), 1'b1), ak);
      check(ak == (sel == int'(MY_STRAP)), "R1 strap match", int'(ak), int'(sel == int'(MY_STRAP)));
      recvByte(1'b0, got);
      if (sel != int'(MY_STRAP))
        check(got == 8'hFF, "R1 released on mismatch", got, 8'hFF);
      busStop();
    end
    busStart();
    sendByte({4'b1011, MY_STRAP, 1'b1}, ak);
    check(!ak, "R1 wrong type nibble", int'(ak), 0);
    recvByte(1'b0, got);
    check(got == 8'hFF, "R1 released on wrong nibble", got, 8'hFF);
    busStop();

    // Burst writes, wrap, random read (R8) and current-address continuation (R10)
    for (int b = 0; b < 3; b++) begin
      setPtr(15'(bases[b]));
      for (int k = 0; k < 5; k++) begin
        got = dataFor((bases[b] + k) & 16'h7FFF, b);
        sendByte(got, ak);
        check(ak, "R4 burst data ack", int'(ak), 1);
        model[(bases[b] + k) & 8'hFF] = got;
      end
      busStop();
      setPtr(15'(bases[b]));
      readRun(bases[b] & 8'hFF, 4, "R8 R3 R4 random read burst");
      readRun((bases[b] + 4) & 8'hFF, 1, "R10 current read continues");
    end

    // R6: protected write
    wp = 1'b1;
    setPtr(15'h0010);
    sendByte(8'h5A, ak);
    check(!ak, "R6 protected data NACK", int'(ak), 0);
    busStop();
    wp = 1'b0;
    readRun(8'h10, 1, "R6 pointer frozen and array unchanged");

    // R5: stop after five bits leaves the array unchanged
    setPtr(15'h0011);
    for (int i = 7; i >= 3; i--) bitOut(got[i] ^ 1'b1);
    busStop();
    setPtr(15'h0011);
    readRun(8'h11, 1, "R5 stop abort keeps array");

    // R9: repeated start after four bits aborts; read uses loaded pointer
    setPtr(15'h0012);
    for (int i = 0; i < 4; i++) bitOut(1'b1);
    readRun(8'h12, 2, "R9 start abort then read");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule